// File: doc/BRIEF.md
# Card Command and Response Sequencer

This block issues a single command to a memory card and gathers the card's reply for a host controller. Software loads a 6-bit command index and a 32-bit argument, which it writes as two independent 16-bit halves. It then writes a command control word. The command is launched once two conditions hold together: a command request is pending, and the card clock is running. These two conditions may be met in either order.

The card side uses a simple transaction. The block raises `card_req` for one cycle with the index and argument. The card then streams its response bytes, one per cycle, and closes the transaction with `card_end`. The block counts the bytes it receives. It compares that count with the minimum that the response-type code demands. If the response is long enough, the block packs the bytes into a nine-word response store, which software drains one word per read. If too few bytes arrived, the block flags a response timeout. When the control word asks for a data phase, the block pulses `data_load` together with the byte count for the companion FIFO engine.

A four-state machine sequences the work:

- IDLE goes to ISSUE on a start.
- ISSUE always goes to WAIT_RESP. In ISSUE, `card_req` is high and the store is cleared.
- WAIT_RESP goes back to IDLE on `card_end` when there is no data phase or the response is too short.
- WAIT_RESP goes to DATA on `card_end` after a long-enough response with data enabled.
- DATA always goes to IDLE.
- From any state, a start goes to ISSUE. A clock stop or a control-word write that does not start goes to IDLE.

Top module: `card_cmd_seq`

## Requirements
- R1: After a synchronous reset, the following reads return these values: status (address 1) reads 0, the command register (address 3) reads 0x0040, and the response port (address 6) reads 0. The outputs `card_req`, `cmd_done` and `data_load` are low.
- R2: A write to address 3 keeps the low 6 bits as the index. A read of address 3 returns the index ORed with 0x0040. Addresses 4 and 5 hold the upper and lower argument halves. A write to one half leaves the other half unchanged, and `card_arg` presents both halves as {upper, lower}.
- R3: A write to address 2 stores the value ANDed with 0x3dff, readable at address 2, and marks a request pending. When bit 10 of the written value is clear and status bit 8 is set, the command starts on that write. When bit 10 is set, no command starts.
- R4: A write to address 0 behaves as follows:
  - Bit 1 sets status bit 8 (clock running).
  - If bit 1 is written while a request is pending and the stored control bit 10 is clear, the command starts.
  - Bit 0 clears status bit 8 and abandons any command in flight.
  - When bits 0 and 1 are written together, bit 0 wins and nothing starts.
- R5: On a start, every status bit except bit 8 is cleared and bit 8 is set. In the following cycle, `card_req` is high for exactly one cycle, with `card_cmd` and `card_arg` showing the stored index and argument.
- R6: Control bits 1:0 select the response type. Code 0 needs no bytes. Codes 1 and 3 need at least 4 bytes. Code 2 needs at least 16 bytes. A shorter response sets status bit 1, leaves every response word at 0 and returns to IDLE.
- R7: After an accepted response, word k of the store is {byte 2k+1, byte 2k}, with the earlier byte in the low half. Words beyond the received bytes read 0. Bytes beyond 18 are dropped.
- R8: Each read of address 6 returns the next stored word, starting from word 0 after an accepted response. After all nine words have been read, every further read returns 0.
- R9: An accepted response sets status bit 13. If control bit 2 is set, `data_load` is high for one cycle, in the cycle after `card_end`, with `data_bytes` equal to (address 8 value) × (address 7 value). Otherwise, `data_load` stays low.
- R10: `cmd_done` is high during the `card_end` cycle of every issued command, whether or not it timed out and whatever its response type. It stays low when `card_end` arrives after the command was abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the response port) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| card_req | output | 1 | One-cycle command request to the card |
| card_cmd | output | 6 | Command index to the card |
| card_arg | output | 32 | Command argument to the card |
| card_byte_vld | input | 1 | Response byte valid |
| card_byte | input | 8 | Response byte |
| card_end | input | 1 | End of card response |
| cmd_done | output | 1 | Command-complete pulse |
| data_load | output | 1 | Data-phase start pulse |
| data_bytes | output | 28 | Data byte count, valid with data_load |

## Verification
The bench uses the default parameters: a nine-word response store, 12-bit block length and 16-bit block count. With a nine-word store, the ninth word and the read past the end are both reachable after a full 16-byte reply. These widths also make a 512 × 3 data count easy to check. The stimulus exercises every response code at both its minimum length and one byte short. It also covers both start orderings, the stop-transfer block, and an abort in mid-response.

// File: rtl/card_cmd_seq_pkg.sv
package card_cmd_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT_RESP,
        ST_DATA
    } seq_state_t;

    localparam logic [3:0] A_CLK  = 4'd0;
    localparam logic [3:0] A_STAT = 4'd1;
    localparam logic [3:0] A_CTRL = 4'd2;
    localparam logic [3:0] A_CMD  = 4'd3;
    localparam logic [3:0] A_ARGH = 4'd4;
    localparam logic [3:0] A_ARGL = 4'd5;
    localparam logic [3:0] A_RESP = 4'd6;
    localparam logic [3:0] A_BLEN = 4'd7;
    localparam logic [3:0] A_NBLK = 4'd8;

    localparam int S_TOUT   = 1;
    localparam int S_CLKEN  = 8;
    localparam int S_ENDRES = 13;
    localparam int C_DATAEN = 2;
    localparam int C_STOP   = 10;

    localparam logic [15:0] CTRL_MASK = 16'h3dff;

    function automatic int unsigned min_resp_len(input logic [1:0] code);
        case (code)
            2'd0:    return 0;
            2'd2:    return 16;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/card_resp_store.sv
module card_resp_store #(
    parameter int WORDS = 9,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             rewind,
    input  logic             byte_vld,
    input  logic [7:0]       byte_in,
    input  logic             pop,
    output logic [15:0]      rd_word,
    output logic [CNT_W-1:0] cnt
);
    localparam int BYTES = 2 * WORDS;
    localparam int PTR_W = $clog2(WORDS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [7:0]       mem [BYTES];
    logic [15:0]      words [WORDS];
    logic [PTR_W-1:0] ptr;

    genvar g;
    generate
        for (g = 0; g < WORDS; g++) begin : g_word
            assign words[g] = {mem[2*g+1], mem[2*g]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < BYTES; i++) mem[i] <= '0;
            cnt <= '0;
            ptr <= '0;
        end else begin
            if (byte_vld) begin
                if (32'(cnt) < BYTES) mem[cnt] <= byte_in;
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end
            if (rewind)
                ptr <= '0;
            else if (pop && 32'(ptr) < WORDS)
                ptr <= ptr + 1'b1;
        end
    end

    assign rd_word = (32'(ptr) < WORDS) ? words[ptr] : 16'h0000;

endmodule

// File: rtl/card_seq_fsm.sv
module card_seq_fsm
    import card_cmd_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic abort,
    input  logic card_end,
    input  logic resp_ok,
    input  logic data_en,
    output logic card_req,
    output logic in_wait,
    output logic cmd_done,
    output logic end_ok,
    output logic end_short,
    output logic data_load
);
    seq_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (go) begin
            nxt = ST_ISSUE;
        end else if (abort) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ISSUE:     nxt = ST_WAIT_RESP;
                ST_WAIT_RESP: if (card_end) nxt = (resp_ok && data_en) ? ST_DATA : ST_IDLE;
                ST_DATA:      nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        card_req  = (state == ST_ISSUE);
        in_wait   = (state == ST_WAIT_RESP);
        cmd_done  = in_wait && card_end && !go && !abort;
        end_ok    = cmd_done && resp_ok;
        end_short = cmd_done && !resp_ok;
        data_load = (state == ST_DATA);
    end

endmodule

// File: rtl/card_cmd_seq.sv
module card_cmd_seq
    import card_cmd_seq_pkg::*;
#(
    parameter int BLEN_W     = 12,
    parameter int NBLK_W     = 16,
    parameter int RESP_WORDS = 9,
    parameter int CMD_W      = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [3:0]               reg_addr,
    input  logic [15:0]              reg_wdata,
    output logic [15:0]              reg_rdata,
    output logic                     card_req,
    output logic [CMD_W-1:0]         card_cmd,
    output logic [31:0]              card_arg,
    input  logic                     card_byte_vld,
    input  logic [7:0]               card_byte,
    input  logic                     card_end,
    output logic                     cmd_done,
    output logic                     data_load,
    output logic [BLEN_W+NBLK_W-1:0] data_bytes
);
    localparam int CNT_W = $clog2(2 * RESP_WORDS + 1);
    localparam int DB_W  = BLEN_W + NBLK_W;

    logic [15:0]       status_q, ctrl_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [31:0]       arg_q;
    logic [BLEN_W-1:0] blen_q;
    logic [NBLK_W-1:0] nblk_q;
    logic              pending_q;

    logic wr_clk, wr_ctrl, clk_start, clk_stop, go, abort;
    logic in_wait, end_ok, end_short, resp_ok;
    logic [15:0]      resp_word;
    logic [CNT_W-1:0] resp_cnt;

    assign wr_clk    = reg_wr && reg_addr == A_CLK;
    assign wr_ctrl   = reg_wr && reg_addr == A_CTRL;
    assign clk_stop  = wr_clk && reg_wdata[0];
    assign clk_start = wr_clk && reg_wdata[1] && !reg_wdata[0];
    assign go        = (wr_ctrl && !reg_wdata[C_STOP] && status_q[S_CLKEN])
                     || (clk_start && pending_q && !ctrl_q[C_STOP]);
    assign abort     = clk_stop || wr_ctrl;
    assign resp_ok   = 32'(resp_cnt) >= min_resp_len(ctrl_q[1:0]);

    card_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .abort     (abort),
        .card_end  (card_end),
        .resp_ok   (resp_ok),
        .data_en   (ctrl_q[C_DATAEN]),
        .card_req  (card_req),
        .in_wait   (in_wait),
        .cmd_done  (cmd_done),
        .end_ok    (end_ok),
        .end_short (end_short),
        .data_load (data_load)
    );

    card_resp_store #(
        .WORDS (RESP_WORDS),
        .CNT_W (CNT_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (card_req || end_short),
        .rewind   (end_ok),
        .byte_vld (card_byte_vld && in_wait),
        .byte_in  (card_byte),
        .pop      (reg_rd && reg_addr == A_RESP),
        .rd_word  (resp_word),
        .cnt      (resp_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q  <= '0;
            ctrl_q    <= '0;
            cmd_q     <= '0;
            arg_q     <= '0;
            blen_q    <= '0;
            nblk_q    <= '0;
            pending_q <= 1'b0;
        end else begin
            if (go) begin
                status_q <= 16'(1) << S_CLKEN;
            end else begin
                if (clk_start) status_q[S_CLKEN]  <= 1'b1;
                if (clk_stop)  status_q[S_CLKEN]  <= 1'b0;
                if (end_ok)    status_q[S_ENDRES] <= 1'b1;
                if (end_short) status_q[S_TOUT]   <= 1'b1;
            end
            if (go)           pending_q <= 1'b0;
            else if (wr_ctrl) pending_q <= 1'b1;
            if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_MASK;
            if (reg_wr) begin
                unique case (reg_addr)
                    A_CMD:   cmd_q         <= reg_wdata[CMD_W-1:0];
                    A_ARGH:  arg_q[31:16]  <= reg_wdata;
                    A_ARGL:  arg_q[15:0]   <= reg_wdata;
                    A_BLEN:  blen_q        <= reg_wdata[BLEN_W-1:0];
                    A_NBLK:  nblk_q        <= reg_wdata[NBLK_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_STAT:  reg_rdata = status_q;
            A_CTRL:  reg_rdata = ctrl_q;
            A_CMD:   reg_rdata = 16'(cmd_q) | 16'h0040;
            A_ARGH:  reg_rdata = arg_q[31:16];
            A_ARGL:  reg_rdata = arg_q[15:0];
            A_RESP:  reg_rdata = resp_word;
            A_BLEN:  reg_rdata = 16'(blen_q);
            A_NBLK:  reg_rdata = 16'(nblk_q);
            default: reg_rdata = 16'h0000;
        endcase
    end

    assign card_cmd   = cmd_q;
    assign card_arg   = arg_q;
    assign data_bytes = DB_W'(nblk_q) * DB_W'(blen_q);

endmodule

// File: rtl/card_cmd_seq_chk.sv
module card_cmd_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [3:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        card_req,
    input logic        cmd_done,
    input logic        data_load,
    input logic [15:0] stat
);
    // R5
    card_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        card_req |=> !card_req);

    // R5
    start_status_chk: assert property (@(posedge clk) disable iff (rst)
        card_req |-> stat == 16'h0100);

    // R10
    cmd_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_done |=> !cmd_done);

    // R9
    data_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        data_load |-> $past(cmd_done));

    // R6
    timeout_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat[1]) |-> $past(cmd_done));

    // R4
    stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'd0 && reg_wdata[0]) |=> !stat[8]);

endmodule

bind card_cmd_seq card_cmd_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .card_req  (card_req),
    .cmd_done  (cmd_done),
    .data_load (data_load),
    .stat      (status_q)
);

// File: tb/test_card_cmd_seq.sv
module test_card_cmd_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        card_req, cmd_done, data_load;
    logic [5:0]  card_cmd;
    logic [31:0] card_arg;
    logic        card_byte_vld = 1'b0, card_end = 1'b0;
    logic [7:0]  card_byte = '0;
    logic [27:0] data_bytes;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    card_cmd_seq i_card_cmd_seq (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .card_req(card_req), .card_cmd(card_cmd), .card_arg(card_arg),
        .card_byte_vld(card_byte_vld), .card_byte(card_byte), .card_end(card_end),
        .cmd_done(cmd_done), .data_load(data_load), .data_bytes(data_bytes)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (reg_rd) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: actual 0x%0h expected none", reg_rdata);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(32'(reg_rdata), 32'(e), t);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic wait_req(input string tag);
        int n = 0;
        while (!card_req && n < 20) begin
            @(posedge clk); #1; n++;
        end
        chk(32'(card_req), 1, tag);
    endtask

    task automatic no_req(input string tag);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            chk(32'(card_req), 0, tag);
        end
    endtask

    task automatic send(input int n, input logic [7:0] base, input logic exp_done,
                        input logic exp_load, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            card_byte_vld = 1'b1; card_byte = base + 8'(i);
        end
        @(posedge clk); #1;
        card_byte_vld = 1'b0; card_end = 1'b1;
        @(negedge clk);
        chk(32'(cmd_done), 32'(exp_done), tag);
        @(posedge clk); #1;
        card_end = 1'b0;
        chk(32'(data_load), 32'(exp_load), tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk(32'(card_req), 0, "R1 card_req");
        chk(32'(cmd_done), 0, "R1 cmd_done");
        chk(32'(data_load), 0, "R1 data_load");
        rd(4'd1, 16'h0000, "R1 status");
        rd(4'd3, 16'h0040, "R1 cmd");
        rd(4'd6, 16'h0000, "R1 resp");

        // R2 index and argument halves
        wr(4'd3, 16'h00ff);
        rd(4'd3, 16'h007f, "R2 cmd read");
        wr(4'd4, 16'h1234);
        wr(4'd5, 16'habcd);
        wr(4'd4, 16'h5678);
        rd(4'd4, 16'h5678, "R2 arg high");
        rd(4'd5, 16'habcd, "R2 arg low kept");

        // R3 pending without clock, then R4 start by clock
        wr(4'd2, 16'h0001);
        no_req("R3 no start without clock");
        rd(4'd2, 16'h0001, "R3 ctrl read");
        wr(4'd0, 16'h0002);
        wait_req("R4 start on clock");
        chk(32'(card_cmd), 32'h3f, "R5 card_cmd");
        chk(card_arg, 32'h5678abcd, "R5 card_arg");
        @(posedge clk); #1;
        chk(32'(card_req), 0, "R5 one-cycle req");
        send(6, 8'h10, 1'b1, 1'b0, "R10 done type1");
        rd(4'd1, 16'h2100, "R9 status ok");
        rd(4'd6, 16'h1110, "R7 word0");
        rd(4'd6, 16'h1312, "R7 word1");
        rd(4'd6, 16'h1514, "R7 word2");
        for (int i = 3; i < 10; i++) rd(4'd6, 16'h0000, "R8 beyond bytes");

        // R9 data phase with type 2, 16 bytes
        wr(4'd8, 16'd3);
        wr(4'd7, 16'd512);
        wr(4'd2, 16'h0006);
        wait_req("R3 immediate start");
        rd(4'd1, 16'h0100, "R5 status cleared");
        send(16, 8'h20, 1'b1, 1'b1, "R9 data_load");
        chk(32'(data_bytes), 32'd1536, "R9 data_bytes");
        rd(4'd1, 16'h2100, "R9 status");
        for (int k = 0; k < 8; k++)
            rd(4'd6, {8'h21 + 8'(2*k), 8'h20 + 8'(2*k)}, "R7 full word");
        rd(4'd6, 16'h0000, "R8 ninth word");
        rd(4'd6, 16'h0000, "R8 past end");

        // R6 type 2 short
        wr(4'd2, 16'h0002);
        wait_req("R6 start");
        send(4, 8'h40, 1'b1, 1'b0, "R10 done on timeout");
        rd(4'd1, 16'h0102, "R6 timeout status");
        rd(4'd6, 16'h0000, "R6 no response stored");

        // R6 type 0 with no bytes
        wr(4'd2, 16'h0000);
        wait_req("R6 type0 start");
        send(0, 8'h00, 1'b1, 1'b0, "R10 done type0");
        rd(4'd1, 16'h2100, "R6 type0 ok");

        // R6 type 3 at minimum and one short
        wr(4'd2, 16'h0003);
        wait_req("R6 type3 start");
        send(4, 8'ha0, 1'b1, 1'b0, "R10 done type3");
        rd(4'd1, 16'h2100, "R6 type3 ok");
        rd(4'd6, 16'ha1a0, "R7 type3 word0");
        wr(4'd2, 16'h0003);
        wait_req("R6 type3 short start");
        send(3, 8'hb0, 1'b1, 1'b0, "R10 done type3 short");
        rd(4'd1, 16'h0102, "R6 type3 short");

        // R3 stop-transfer blocks start; mask
        wr(4'd2, 16'hffff);
        no_req("R3 stop bit no start");
        rd(4'd2, 16'h3dff, "R3 ctrl mask");
        wr(4'd0, 16'h0002);
        no_req("R4 stop bit blocks clock start");

        // R10 abort mid-response, R4 stop clock
        wr(4'd2, 16'h0001);
        wait_req("R3 restart");
        wr(4'd0, 16'h0001);
        send(4, 8'hc0, 1'b0, 1'b0, "R10 no done after abort");
        rd(4'd1, 16'h0000, "R4 clock stopped");
        wr(4'd0, 16'h0003);
        rd(4'd1, 16'h0000, "R4 stop wins");

        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule